// File: doc/BRIEF.md
# Programmable Watchdog With Reset/Interrupt Steering

This block is a watchdog timer driven by a single 8-bit control register and a
sixteenth-of-a-second tick. Software programs the timeout as a 5-bit multiplier
times a power-of-four resolution. It must then either rewrite or read the
register before that many ticks have passed. If it does not, the watchdog
expires. It always raises a sticky flag, and it then does one of two things.
It asks for a system reset, which also clears the control register and strobes
the century-bit clear of the neighbouring day register. Otherwise it emits a
single interrupt pulse.

The top bit of the control byte picks between the reset and the interrupt
action. The timeout is one-shot: after expiry nothing is armed until the next
restart. A restart is any write of the register, or any read of it. A
multiplier of zero leaves the watchdog idle, and so does an all-zero control
byte.

Top module: `wdog_steer`

## Requirements
- R1: After reset the control register reads 0x00, and `wd_flag`, `rst_req`, `irq_pulse` and `century_clr` are all low.
- R2: The timeout in ticks is `(1 << 2*ctl[1:0]) * ctl[6:2]`. The watchdog expires on exactly the tick that brings the count from the restart value to zero. Its outputs are visible in the cycle after that tick.
- R3: When the multiplier field `ctl[6:2]` is zero, which covers a control value of 0x00, no expiry ever occurs, however many ticks arrive.
- R4: A write stores `ctl_wdata`, which then reads back on `ctl_rdata` from the next cycle. The write also clears `wd_flag` and restarts the count from the full interval of the written value.
- R5: A read (`ctl_rd`) leaves the stored value unchanged. It clears `wd_flag` and restarts the count from the full interval of the stored value.
- R6: Expiry sets `wd_flag`. The flag stays set until the next write or read.
- R7: If `ctl[7]` is 1 at expiry, `rst_req` and `century_clr` pulse high for exactly one cycle, and the control register becomes 0x00.
- R8: If `ctl[7]` is 0 at expiry, `irq_pulse` goes high for exactly one cycle. The control register keeps its value, and `rst_req` stays low.
- R9: A write or a read in the same cycle as a tick takes priority: that tick is not counted, and no expiry comes from it.
- R10: Once the watchdog has expired, further ticks produce no new pulse and do not alter the flag or the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rd | input | 1 | Control register read strobe (restarts the watchdog) |
| ctl_wdata | input | 8 | Control write data: [1:0] resolution, [6:2] multiplier, [7] steer to reset |
| tick | input | 1 | One-cycle pulse every 1/16 second |
| ctl_rdata | output | 8 | Current control register value |
| rst_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| wd_flag | output | 1 | Watchdog-expired flag bit of the flags register |
| century_clr | output | 1 | One-cycle strobe that clears bit 6 of the day/century register |

## Verification
A count that is off by even one tick shows up at the ports. The reset pulse or
the interrupt pulse appears one cycle early or late relative to the Nth tick,
and a model compared every cycle flags it at once. A wrong steering decision
shows in the same cycle, in two ways. The wrong pulse fires, and the control
register either clears or holds when it should not. A restart that is lost
shows within one interval, because the watchdog expires where the model
expects silence. Timeouts at the longest setting and at zero multiplier are
both exercised, so a count that is truncated or wraps would show too.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int RES_W = 2,
  parameter int MUL_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_wr,
  input  logic                       ctl_rd,
  input  logic [RES_W+MUL_W:0]       ctl_wdata,
  input  logic                       tick,
  output logic [RES_W+MUL_W:0]       ctl_rdata,
  output logic                       rst_req,
  output logic                       irq_pulse,
  output logic                       wd_flag,
  output logic                       century_clr
);
  localparam int CTL_W = RES_W + MUL_W + 1;
  localparam int SHMAX = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W = MUL_W + SHMAX;
  localparam int STEER = CTL_W - 1;

  logic [CTL_W-1:0] ctl;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] interval(input logic [CTL_W-1:0] v);
    logic [CNT_W-1:0] m;
    m = CNT_W'(v[RES_W +: MUL_W]);
    return m << (2 * v[RES_W-1:0]);
  endfunction

  assign ctl_rdata = ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl         <= '0;
      cnt         <= '0;
      wd_flag     <= 1'b0;
      rst_req     <= 1'b0;
      irq_pulse   <= 1'b0;
      century_clr <= 1'b0;
    end else begin
      rst_req     <= 1'b0;
      irq_pulse   <= 1'b0;
      century_clr <= 1'b0;
      if (ctl_wr) begin
        ctl     <= ctl_wdata;
        wd_flag <= 1'b0;
        cnt     <= interval(ctl_wdata);
      end else if (ctl_rd) begin
        wd_flag <= 1'b0;
        cnt     <= interval(ctl);
      end else if (tick && cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          wd_flag <= 1'b1;
          if (ctl[STEER]) begin
            rst_req     <= 1'b1;
            century_clr <= 1'b1;
            ctl         <= '0;
          end else begin
            irq_pulse <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             ctl_rd,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             rst_req,
  input logic             irq_pulse,
  input logic             wd_flag,
  input logic             century_clr
);
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);  // R7
  AST_RST_CLEARS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctl_rdata == '0 && century_clr));  // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);  // R8
  AST_STEER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_pulse));  // R8
  AST_EXPIRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq_pulse) |-> wd_flag);  // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !ctl_wr && !ctl_rd) |=> wd_flag);  // R6
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr || ctl_rd) |=> (!wd_flag && !rst_req && !irq_pulse));  // R9
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata == $past(ctl_wdata)));  // R4
endmodule

bind wdog_steer wdog_steer_chk #(.CTL_W(RES_W + MUL_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .rst_req(rst_req),
  .irq_pulse(irq_pulse), .wd_flag(wd_flag), .century_clr(century_clr)
);

// File: tb/tb_wdog_steer.sv
`timescale 1ns/1ps
module tb_wdog_steer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, ctl_rd = 1'b0, tick = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       rst_req, irq_pulse, wd_flag, century_clr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_steer dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .tick(tick), .ctl_rdata(ctl_rdata),
    .rst_req(rst_req), .irq_pulse(irq_pulse), .wd_flag(wd_flag),
    .century_clr(century_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_ctl, m_cnt, m_flag, e_rst, e_irq;
  bit  model_on = 0;

  function automatic int ivl(input int v);
    return (1 << (2 * (v & 3))) * ((v >> 2) & 31);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_cnt = 0; m_flag = 0; e_rst = 0; e_irq = 0;
    end else begin
      e_rst = 0; e_irq = 0;
      if (ctl_wr) begin
        m_ctl = ctl_wdata; m_flag = 0; m_cnt = ivl(ctl_wdata);
      end else if (ctl_rd) begin
        m_flag = 0; m_cnt = ivl(m_ctl);
      end else if (tick && m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_flag = 1;
          if (m_ctl[7]) begin e_rst = 1; m_ctl = 0; end
          else e_irq = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("MODEL ctl", ctl_rdata, m_ctl);
      chk("MODEL flag", wd_flag, m_flag);
      chk("MODEL rst_req", rst_req, e_rst);
      chk("MODEL century_clr", century_clr, e_rst);
      chk("MODEL irq", irq_pulse, e_irq);
    end
  end

  task automatic cyc(input logic wr, input logic rd, input logic [7:0] d, input logic tk);
    ctl_wr = wr; ctl_rd = rd; ctl_wdata = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; ctl_rd = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_on = 1;
    // R1 reset state
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 flag", wd_flag, 0);
    chk("R1 pulses", {rst_req, irq_pulse, century_clr}, 0);

    // interrupt steering: 0x05 -> res 4, mult 1 -> 4 ticks
    cyc(1, 0, 8'h05, 0);
    chk("R4 write stored", ctl_rdata, 8'h05);
    ticks(3);
    chk("R2 no early expiry", irq_pulse, 0);
    ticks(1);
    chk("R2 expiry on 4th tick", irq_pulse, 1);
    chk("R8 no reset on irq", rst_req, 0);
    chk("R6 flag set", wd_flag, 1);
    cyc(0, 0, 8'h00, 0);
    chk("R8 irq one cycle", irq_pulse, 0);
    chk("R8 ctl kept", ctl_rdata, 8'h05);
    ticks(20);
    chk("R10 no repulse", irq_pulse, 0);
    chk("R10 flag held", wd_flag, 1);
    chk("R6 flag sticky", wd_flag, 1);

    // R5 read restarts and clears flag
    cyc(0, 1, 8'h00, 0);
    chk("R5 flag cleared", wd_flag, 0);
    chk("R5 value kept", ctl_rdata, 8'h05);
    ticks(3);
    chk("R5 rearmed no early", irq_pulse, 0);
    ticks(1);
    chk("R5 rearmed expiry", irq_pulse, 1);

    // R9 restart wins over coincident tick
    cyc(1, 0, 8'h05, 0);
    ticks(3);
    cyc(1, 0, 8'h05, 1);
    ticks(3);
    chk("R9 write+tick restarts", irq_pulse, 0);
    ticks(1);
    chk("R9 expiry after full interval", irq_pulse, 1);
    cyc(1, 0, 8'h05, 0);
    ticks(3);
    cyc(0, 1, 8'h00, 1);
    ticks(3);
    chk("R9 read+tick restarts", irq_pulse, 0);
    ticks(1);
    chk("R9 read path expiry", irq_pulse, 1);

    // reset steering: 0x86 -> res 16, mult 1 -> 16 ticks
    cyc(1, 0, 8'h86, 0);
    ticks(15);
    chk("R2 res16 no early", rst_req, 0);
    ticks(1);
    chk("R7 rst_req", rst_req, 1);
    chk("R7 century_clr", century_clr, 1);
    chk("R7 ctl cleared", ctl_rdata, 0);
    chk("R7 no irq", irq_pulse, 0);
    cyc(0, 0, 8'h00, 0);
    chk("R7 rst one cycle", rst_req, 0);
    chk("R7 century one cycle", century_clr, 0);
    ticks(40);
    chk("R10 disarmed after reset expiry", rst_req | irq_pulse, 0);

    // R3 zero multiplier
    cyc(1, 0, 8'h00, 0);
    ticks(100);
    chk("R3 zero ctl silent", {wd_flag, rst_req, irq_pulse}, 0);
    cyc(1, 0, 8'h83, 0);
    ticks(100);
    chk("R3 zero mult silent", {wd_flag, rst_req, irq_pulse}, 0);
    chk("R3 ctl kept", ctl_rdata, 8'h83);

    // R2 longest interval 0xFF -> 64*31 = 1984 ticks
    cyc(1, 0, 8'hFF, 0);
    ticks(1983);
    chk("R2 max no early", rst_req, 0);
    ticks(1);
    chk("R2 max expiry", rst_req, 1);
    chk("R7 max ctl cleared", ctl_rdata, 0);

    // R2 res 64 x mult 2 with sparse ticks, interrupt side
    cyc(1, 0, 8'h0B, 0);
    for (int i = 0; i < 127; i++) begin
      cyc(0, 0, 8'h00, 1);
      cyc(0, 0, 8'h00, 0);
    end
    chk("R2 sparse no early", irq_pulse | wd_flag, 0);
    ticks(1);
    chk("R2 sparse expiry", irq_pulse, 1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule